// File: doc/BRIEF.md
# Five-Level Inverter Gate Modulator

This block produces the five gate drives for a single-phase inverter built from a full H-bridge and one auxiliary bidirectional switch. The auxiliary switch ties the positive load terminal to the midpoint of a split DC-link capacitor. A signed reference sample stream sets the wanted output waveform. An internal triangular carrier, with a programmable peak, sets the switching rate. On every clock the block picks one of five output levels (full positive, half positive, zero, half negative, full negative). It then turns that level into a legal switch pattern and applies it to the gates with a programmable blanking interval.

The block compares the magnitude of the held reference against two thresholds. The lower one is the carrier itself. The upper one is the carrier raised by the carrier peak. This is the same as comparing against two references that differ only by an offset equal to the carrier amplitude. The sign of the reference picks the polarity. The reference is sampled only when the carrier turns around, so a new sample never cuts a PWM pulse in half. The two equivalent zero patterns take turns, so the conduction losses of the zero state are shared between the two halves of the bridge.

Top module: `penta_pwm_mod`

## Requirements
- R1: Gate bit i drives switch S(i+1). The nonzero levels map as follows: full positive to S1+S4 (`01001`), half positive to S5+S4 (`11000`), half negative to S5+S2 (`10010`) and full negative to S2+S3 (`00110`).
- R2: Zero uses either S3+S4 (`01100`) or S1+S2 (`00011`). The pattern is kept for the whole stay in zero and alternates on each new entry into zero. The first entry after enable or reset uses S3+S4.
- R3: While enabled, the carrier starts at 0, rises by one per clock to the amplitude A, falls by one per clock back to 0, and repeats. Its period is 2A clocks, and it stays at 0 when A is 0.
- R4: With magnitude m of the held reference and carrier value c, the level is full when m > c + A, half when m > c, and zero otherwise. A negative reference gives the negative level. levelCode is two's complement: `010` +full, `001` +half, `000` zero, `111` −half, `110` −full.
- R5: The reference input is captured only on a clock where the carrier is 0, or where it is rising and has reached A. A value present on any other clock has no effect.
- R6: levelCode updates one clock after the carrier value and held reference it was decided from.
- R7: A change from one nonzero gate pattern to a different one passes through all gates off for deadTime+1 clocks. After that, the pattern wanted at that moment is applied.
- R8: S1 and S3, S2 and S4, and S5 with S1 or S3 are never on together. Either no gate or exactly two gates are on.
- R9: One clock after enable is sampled low, gates and levelCode are zero. The carrier, the held reference and the zero alternation restart. The first pattern after enable is applied on the next clock with no blanking.
- R10: rstN low asynchronously puts the block in the same state as a disabled one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the modulator; low forces gates off |
| refSample | input | REF_W | Signed reference sample |
| carrierAmp | input | AMP_W | Carrier peak value A |
| deadTime | input | DT_W | Extra blanking clocks between patterns |
| gates | output | 5 | Gate drives, bit 0 = S1 ... bit 4 = S5 |
| levelCode | output | 3 | Selected level, two's complement |

## Verification
levelCode is due one rising edge after the carrier and held-reference values it depends on. The gates follow levelCode one edge later, or deadTime+1 edges later with all gates off when a blanking interval is needed. The bench runs a cycle-stepped model that updates on the same rising edges. It compares gates and levelCode with that model at every falling edge, so each result is checked in the exact cycle it is due. Directed checks sample a fixed number of edges after enable, chosen to land on the first applied pattern and the first decided level.

// File: rtl/penta_pwm_pkg.sv
`timescale 1ns/1ps
package penta_pwm_pkg;

  localparam int NUM_SW = 5;

  typedef enum logic [2:0] {
    LV_ZERO     = 3'b000,
    LV_POS_HALF = 3'b001,
    LV_POS_FULL = 3'b010,
    LV_NEG_FULL = 3'b110,
    LV_NEG_HALF = 3'b111
  } level_e;

  typedef logic [NUM_SW-1:0] swPat_t;

  // bit0=S1 bit1=S2 bit2=S3 bit3=S4 bit4=S5
  localparam swPat_t PAT_POS_FULL = 5'b01001;
  localparam swPat_t PAT_POS_HALF = 5'b11000;
  localparam swPat_t PAT_ZERO_LO  = 5'b01100;
  localparam swPat_t PAT_ZERO_HI  = 5'b00011;
  localparam swPat_t PAT_NEG_HALF = 5'b10010;
  localparam swPat_t PAT_NEG_FULL = 5'b00110;

  typedef struct packed {
    logic clear;
    logic advance;
    logic latchRef;
  } dpStrobe_t;

  function automatic swPat_t levelToPat(level_e lv, logic altZero);
    case (lv)
      LV_POS_FULL: return PAT_POS_FULL;
      LV_POS_HALF: return PAT_POS_HALF;
      LV_NEG_HALF: return PAT_NEG_HALF;
      LV_NEG_FULL: return PAT_NEG_FULL;
      default:     return altZero ? PAT_ZERO_HI : PAT_ZERO_LO;
    endcase
  endfunction

endpackage

// File: rtl/penta_pwm_dp.sv
`timescale 1ns/1ps
module penta_pwm_dp
  import penta_pwm_pkg::*;
#(
  parameter int REF_W = 12,
  parameter int AMP_W = 10
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  dpStrobe_t               strobe,
  input  logic signed [REF_W-1:0] refIn,
  input  logic [AMP_W-1:0]        amp,
  output logic                    atTurn,
  output level_e                  levelQ
);

  localparam int CMP_W = ((REF_W > AMP_W) ? REF_W : AMP_W) + 2;

  logic [AMP_W-1:0]        carrier, carrierNext;
  logic                    dirUp, dirUpNext;
  logic signed [REF_W-1:0] refHeld;
  logic [REF_W-1:0]        refMag;
  logic [CMP_W-1:0]        magExt, halfThr, fullThr;
  level_e                  levelNext;

  // turning points of the triangle: valley, or rising and at/above peak
  assign atTurn = (carrier == '0) || (dirUp && (carrier >= amp));

  // triangle carrier stepping
  always_comb begin
    carrierNext = carrier;
    dirUpNext   = dirUp;
    if (dirUp) begin
      if (carrier < amp) begin
        carrierNext = carrier + AMP_W'(1);
      end else begin
        dirUpNext   = 1'b0;
        carrierNext = (carrier != '0) ? carrier - AMP_W'(1) : '0;
      end
    end else begin
      if (carrier != '0) begin
        carrierNext = carrier - AMP_W'(1);
      end else begin
        dirUpNext   = 1'b1;
        carrierNext = (amp != '0) ? AMP_W'(1) : '0;
      end
    end
  end

  // magnitude against lower and offset-upper thresholds
  always_comb begin
    refMag  = refHeld[REF_W-1] ? REF_W'(-refHeld) : REF_W'(refHeld);
    magExt  = CMP_W'(refMag);
    halfThr = CMP_W'(carrier);
    fullThr = CMP_W'(carrier) + CMP_W'(amp);
    if (magExt > fullThr) begin
      levelNext = refHeld[REF_W-1] ? LV_NEG_FULL : LV_POS_FULL;
    end else if (magExt > halfThr) begin
      levelNext = refHeld[REF_W-1] ? LV_NEG_HALF : LV_POS_HALF;
    end else begin
      levelNext = LV_ZERO;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      carrier <= '0;
      dirUp   <= 1'b1;
      refHeld <= '0;
      levelQ  <= LV_ZERO;
    end else if (strobe.clear) begin
      carrier <= '0;
      dirUp   <= 1'b1;
      refHeld <= '0;
      levelQ  <= LV_ZERO;
    end else if (strobe.advance) begin
      carrier <= carrierNext;
      dirUp   <= dirUpNext;
      levelQ  <= levelNext;
      if (strobe.latchRef) begin
        refHeld <= refIn;
      end
    end
  end

endmodule

// File: rtl/penta_pwm_ctl.sv
`timescale 1ns/1ps
module penta_pwm_ctl
  import penta_pwm_pkg::*;
#(
  parameter int DT_W = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            enable,
  input  logic            atTurn,
  input  level_e          levelQ,
  input  logic [DT_W-1:0] deadTime,
  output dpStrobe_t       strobe,
  output swPat_t          gates
);

  swPat_t          gateQ, wantPat;
  logic [DT_W-1:0] dtCnt;
  logic            zeroSel;
  logic            curIsZero;

  always_comb begin
    strobe.clear    = !enable;
    strobe.advance  = enable;
    strobe.latchRef = enable && atTurn;
  end

  // keep the zero pair already in use; otherwise pick by alternation
  always_comb begin
    curIsZero = (gateQ == PAT_ZERO_LO) || (gateQ == PAT_ZERO_HI);
    if ((levelQ == LV_ZERO) && curIsZero) begin
      wantPat = gateQ;
    end else begin
      wantPat = levelToPat(levelQ, zeroSel);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gateQ   <= '0;
      dtCnt   <= '0;
      zeroSel <= 1'b0;
    end else if (!enable) begin
      gateQ   <= '0;
      dtCnt   <= '0;
      zeroSel <= 1'b0;
    end else if (dtCnt != '0) begin
      dtCnt <= dtCnt - DT_W'(1);
    end else if (gateQ == '0) begin
      gateQ <= wantPat;
      if (levelQ == LV_ZERO) begin
        zeroSel <= ~zeroSel;
      end
    end else if (wantPat != gateQ) begin
      gateQ <= '0;
      dtCnt <= deadTime;
    end
  end

  assign gates = gateQ;

endmodule

// File: rtl/penta_pwm_mod.sv
`timescale 1ns/1ps
module penta_pwm_mod
  import penta_pwm_pkg::*;
#(
  parameter int REF_W = 12,
  parameter int AMP_W = 10,
  parameter int DT_W  = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    enable,
  input  logic signed [REF_W-1:0] refSample,
  input  logic [AMP_W-1:0]        carrierAmp,
  input  logic [DT_W-1:0]         deadTime,
  output logic [4:0]              gates,
  output logic [2:0]              levelCode
);

  dpStrobe_t strobe;
  logic      atTurn;
  level_e    levelQ;
  swPat_t    gatePat;

  penta_pwm_dp #(.REF_W(REF_W), .AMP_W(AMP_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .refIn  (refSample),
    .amp    (carrierAmp),
    .atTurn (atTurn),
    .levelQ (levelQ)
  );

  penta_pwm_ctl #(.DT_W(DT_W)) u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (enable),
    .atTurn   (atTurn),
    .levelQ   (levelQ),
    .deadTime (deadTime),
    .strobe   (strobe),
    .gates    (gatePat)
  );

  assign gates     = gatePat;
  assign levelCode = levelQ;

endmodule

// File: rtl/penta_pwm_chk.sv
`timescale 1ns/1ps
module penta_pwm_chk #(
  parameter int DT_W = 4
) (
  input logic            clk,
  input logic            rstN,
  input logic            enable,
  input logic [DT_W-1:0] deadTime,
  input logic [4:0]      gates,
  input logic [2:0]      levelCode
);

  localparam int RUN_W = DT_W + 2;
  localparam logic [RUN_W-1:0] RUN_MAX = '1;

  logic [RUN_W-1:0] offRun;
  logic [DT_W-1:0]  dtAtFall;
  logic             hadPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      offRun   <= '0;
      dtAtFall <= '0;
      hadPrev  <= 1'b0;
    end else if (!enable) begin
      offRun   <= '0;
      hadPrev  <= 1'b0;
    end else if (gates == '0) begin
      if (offRun != RUN_MAX) offRun <= offRun + RUN_W'(1);
    end else begin
      offRun   <= '0;
      dtAtFall <= deadTime;
      hadPrev  <= 1'b1;
    end
  end

  p_leg_conflict_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(gates[0] && gates[2]) && !(gates[1] && gates[3]) && !(gates[4] && (gates[0] || gates[2])));

  p_pair_count_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(gates) == 0) || ($countones(gates) == 2));

  p_via_off_r7: assert property (@(posedge clk) disable iff (!rstN)
    (gates != '0) && ($past(gates) != '0) |-> gates == $past(gates));

  p_blank_len_r7: assert property (@(posedge clk) disable iff (!rstN)
    enable && hadPrev && (gates != '0) && ($past(gates) == '0) |-> offRun > RUN_W'(dtAtFall));

  p_disable_off_r9: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (gates == '0) && (levelCode == 3'b000));

endmodule

bind penta_pwm_mod penta_pwm_chk #(.DT_W(DT_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .enable    (enable),
  .deadTime  (deadTime),
  .gates     (gates),
  .levelCode (levelCode)
);

// File: tb/penta_pwm_mod_test.sv
`timescale 1ns/1ps
module penta_pwm_mod_test;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               en = 1'b0;
  logic signed [11:0] refS = '0;
  logic [9:0]         amp = '0;
  logic [3:0]         dt = '0;
  logic [4:0]         gates;
  logic [2:0]         levelCode;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  penta_pwm_mod uut (
    .clk(clk), .rstN(rstN), .enable(en), .refSample(refS),
    .carrierAmp(amp), .deadTime(dt), .gates(gates), .levelCode(levelCode)
  );

  // ---- behavioural model built from the requirements ----
  function automatic int decideLvl(int r, int c, int a);
    int m = (r < 0) ? -r : r;
    int s = (r < 0) ? -1 : 1;
    if (m > c + a) return 2 * s;      // R4 full
    else if (m > c) return s;         // R4 half
    return 0;
  endfunction

  function automatic logic [4:0] patOf(int lv, bit zs);
    case (lv)
      2:  return 5'b01001;
      1:  return 5'b11000;
      -1: return 5'b10010;
      -2: return 5'b00110;
      default: return zs ? 5'b00011 : 5'b01100;
    endcase
  endfunction

  int         mCar, mRef, mLvl, mDt;
  bit         mUp, mZs;
  logic [4:0] mGate;

  always @(posedge clk or negedge rstN) begin
    int a, nc, want;
    bit nu, turn;
    logic [4:0] wp;
    if (!rstN || !en) begin
      mCar <= 0; mUp <= 1; mRef <= 0; mLvl <= 0; mDt <= 0; mZs <= 0; mGate <= '0;
    end else begin
      a = int'(amp);
      turn = (mCar == 0) || (mUp && mCar >= a);   // R5
      nc = mCar; nu = mUp;                        // R3
      if (mUp) begin
        if (mCar < a) nc = mCar + 1;
        else begin nu = 0; nc = (mCar != 0) ? mCar - 1 : 0; end
      end else begin
        if (mCar != 0) nc = mCar - 1;
        else begin nu = 1; nc = (a != 0) ? 1 : 0; end
      end
      mCar <= nc; mUp <= nu;
      if (turn) mRef <= int'(refS);
      mLvl <= decideLvl(mRef, mCar, a);           // R6 one register
      want = 0;
      wp = ((mLvl == 0) && (mGate == 5'b01100 || mGate == 5'b00011)) ? mGate : patOf(mLvl, mZs);
      if (mDt != 0) mDt <= mDt - 1;               // R7 blanking
      else if (mGate == 0) begin
        mGate <= wp;
        if (mLvl == 0) mZs <= !mZs;               // R2
      end else if (wp != mGate) begin
        mGate <= '0; mDt <= int'(dt);
      end
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic bit legalPat(logic [4:0] g);
    return g == 5'b00000 || g == 5'b01001 || g == 5'b11000 || g == 5'b01100 ||
           g == 5'b00011 || g == 5'b10010 || g == 5'b00110;
  endfunction

  // advance one clock, then compare at the falling edge
  task automatic tick(string lvlTag);
    @(posedge clk);
    @(negedge clk);
    chk(levelCode == 3'(mLvl), lvlTag, int'(levelCode), int'(3'(mLvl)));
    chk(gates == mGate, "R7 gates", int'(gates), int'(mGate));
    chk(legalPat(gates), "R8 legal pattern", int'(gates), 0);
  endtask

  task automatic ticks(int n, string lvlTag);
    for (int i = 0; i < n; i++) tick(lvlTag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    int unsigned seedv;
    int span;
    seedv = $urandom(32'd7321);
    // R10 reset state
    repeat (3) @(negedge clk);
    chk(gates == 5'b0, "R10 gates in reset", int'(gates), 0);
    chk(levelCode == 3'b0, "R10 level in reset", int'(levelCode), 0);
    rstN = 1'b1;
    ticks(2, "R9");

    // R2 first zero entry picks S3+S4, then alternation
    amp = 10'd3; dt = 4'd2; refS = 12'sd0; en = 1'b1;
    tick("R9");
    chk(gates == 5'b01100, "R2 first zero pair", int'(gates), 'h0c);
    ticks(6, "R3");
    refS = 12'sd3; ticks(14, "R4");
    refS = 12'sd0; ticks(14, "R2");
    refS = -12'sd3; ticks(14, "R4");
    refS = 12'sd0; ticks(14, "R2");

    // R9 disable clears outputs one clock later
    en = 1'b0; tick("R9");
    chk(gates == 5'b0, "R9 gates off", int'(gates), 0);
    chk(levelCode == 3'b0, "R9 level zero", int'(levelCode), 0);

    // R6 latency with A=0, then R1 full positive pattern
    amp = 10'd0; refS = 12'sd5; en = 1'b1;
    tick("R6");
    chk(levelCode == 3'b000, "R6 level before decision", int'(levelCode), 0);
    tick("R6");
    chk(levelCode == 3'b010, "R6 level after one clock", int'(levelCode), 2);
    ticks(30, "R4");
    chk(gates == 5'b01001, "R1 full positive gates", int'(gates), 'h09);

    // R4 most negative reference gives full negative
    refS = -12'sd2048; ticks(30, "R4");
    chk(levelCode == 3'b110, "R4 full negative code", int'(levelCode), 6);
    chk(gates == 5'b00110, "R1 full negative gates", int'(gates), 'h06);

    // R5 mid-sweep sample ignored
    en = 1'b0; tick("R9");
    amp = 10'd20; refS = 12'sd0; en = 1'b1;
    ticks(5, "R3");
    refS = 12'sd100; tick("R5");
    refS = 12'sd0;
    for (int i = 0; i < 30; i++) begin
      tick("R5");
      chk(levelCode == 3'b000, "R5 ignored sample", int'(levelCode), 0);
    end

    // random runs
    for (int run = 0; run < 24; run++) begin
      en = 1'b0; ticks(2, "R9");
      case (run % 4)
        0: amp = 10'($urandom_range(0, 2));
        1: amp = 10'($urandom_range(3, 8));
        default: amp = 10'($urandom_range(9, 40));
      endcase
      dt = 4'($urandom_range(0, 15));
      en = 1'b1;
      span = 2 * int'(amp) + 6;
      for (int c = 0; c < 300; c++) begin
        if ($urandom_range(0, 7) == 0) begin
          case ($urandom_range(0, 19))
            0: refS = -12'sd2048;
            1: refS = 12'sd2047;
            default: refS = 12'($signed($urandom_range(0, 2 * span)) - span);
          endcase
        end
        if ($urandom_range(0, 99) == 0) dt = 4'($urandom_range(0, 15));
        if ($urandom_range(0, 199) == 0) en = 1'b0;
        else en = 1'b1;
        tick("R3");
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule